// File: doc/BRIEF.md
# Gate Driver Control Unit

This block sits between six PWM timer outputs and six gate driver control lines, three for low-side switches and three for high-side switches. Each PWM input is tied to one fixed driver line. Every edge is passed on only after a programmable propagation delay. The delay for a rising edge differs from the delay for a falling edge, and the low-side lines use a different table from the high-side lines. The delay comes from nanosecond values rounded up to whole clock cycles. A pulse that is shorter than the delay for its edge never reaches the driver line.

All driver lines stay low after reset until software sets the enable bit. A protection event input sets a sticky fault flag. While the flag is set, each driver group whose mask bit is set is forced low. Software clears the flag with a clear strobe, and only while the event input is low. Shutdown by a fault or by a disable takes effect at the clock edge that samples it, without waiting for any edge delay. A small write-only register port loads the controls. Inputs and outputs are plain level signals, so no valid/ready handshake and no back-pressure apply.

Top module: `gate_drive_ctrl`

## Requirements
- R1: After reset, all driver outputs are low. The enable bit is 0, the delay setting is 0 and both mask bits are 0.
- R2: While the enable bit (address 0, data bit 0) is 0, every driver output stays low whatever the PWM inputs do. After enable is set, a PWM input that is held high appears at its output once the rising delay has elapsed.
- R3: pwm_in[0..2] drive drv_lo[0..2], and pwm_in[3..5] drive drv_hi[0..2], in index order.
- R4: The low-side delays for the setting at address 1, data bits [1:0], codes 0 to 3, are as follows. Rising: 130, 170, 230 and 360 ns. Falling: 140, 180, 250 and 380 ns. Each value becomes ceil(ns/CLK_NS) cycles, which at 5 ns gives 26/34/46/72 rising and 28/36/50/76 falling. The count runs from the first clock edge that samples the new input level to the edge at which the output changes.
- R5: The high-side delays are as follows. Rising: 160, 200, 260 and 380 ns, which at 5 ns gives 32/40/52/76 cycles. Falling: 140, 180, 240 and 370 ns, which at 5 ns gives 28/36/48/74 cycles. They are rounded the same way as in R4.
- R6: An output changes only after its input has held the new level for the full delay of that edge direction. Shorter pulses are filtered out.
- R7: The delay of an edge is fixed at the first clock edge that samples it. A new delay setting written while that edge is being timed applies only from the next edge.
- R8: A high protection event at a clock edge sets the fault flag. This happens whatever the mask bits are. While the flag is set, mask bit 0 (address 2, data bit 0) forces the low-side group low and mask bit 1 forces the high-side group low. The forcing starts at that same edge.
- R9: The fault flag stays set until a write of data bit 0 = 1 to address 3 while the event input is low. A clear written while the event is high is ignored. After a clear, the outputs follow their inputs again through the rising delay.
- R10: Writing 0 to the enable bit forces every output low at the write edge.
- R11: A group whose mask bit is 0 keeps following its PWM inputs while the fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 enable, 1 delay setting, 2 mask, 3 fault clear |
| cfg_wdata | input | 2 | Register write data |
| prot_evt | input | 1 | Protection event, active high |
| pwm_in | input | 6 | PWM inputs: 0..2 low side, 3..5 high side |
| drv_lo | output | 3 | Low-side driver controls |
| drv_hi | output | 3 | High-side driver controls |

## Verification
The bench measures every edge delay for each setting on both driver sides. A design that swapped the tables or truncated the rounding would miss by at least one cycle. It sends pulses one cycle shorter than the delay. A filter that passes these, or that counts one cycle too few, lets a glitch through. It changes the delay setting halfway through a timed edge. A design that reads the setting live would then stretch that edge. It also tries a fault clear while the event is still high, raises an event with only one mask bit set, and disables the block with the outputs high. A wrong design would release the fault early, shut down the wrong group, or drop the outputs late. Long random runs compare every output in every cycle against a bench model.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_DELAY  = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_CLEAR  = 2'd3
  } cfg_addr_e;

  // Edge propagation time in ns for a driver side, edge direction and setting
  function automatic int edge_ns(input logic high_side, input logic rising,
                                 input logic [1:0] sel);
    int ns;
    ns = 0;
    case ({high_side, rising})
      2'b01: case (sel) 2'd0: ns = 130; 2'd1: ns = 170; 2'd2: ns = 230; default: ns = 360; endcase
      2'b00: case (sel) 2'd0: ns = 140; 2'd1: ns = 180; 2'd2: ns = 250; default: ns = 380; endcase
      2'b11: case (sel) 2'd0: ns = 160; 2'd1: ns = 200; 2'd2: ns = 260; default: ns = 380; endcase
      default: case (sel) 2'd0: ns = 140; 2'd1: ns = 180; 2'd2: ns = 240; default: ns = 370; endcase
    endcase
    return ns;
  endfunction

  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_cycles(input int clk_ns);
    int m;
    m = 1;
    for (int hs = 0; hs < 2; hs++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 4; s++) begin
          int c;
          c = ns_to_cycles(edge_ns(hs[0], r[0], s[1:0]), clk_ns);
          if (c > m) m = c;
        end
    return m;
  endfunction

endpackage

// File: rtl/gdc_regs.sv
module gdc_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [1:0] cfg_wdata,
  input  logic       prot_evt,
  output logic [1:0] sel_q,
  output logic       kill_lo,
  output logic       kill_hi
);
  import gdc_pkg::*;

  logic       en_q;
  logic [1:0] mask_q;
  logic       flt_q;
  logic       clr_req;

  assign clr_req = cfg_we && (cfg_addr == ADDR_CLEAR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 2'd0;
      mask_q <= 2'b00;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_ENABLE: en_q   <= cfg_wdata[0];
        ADDR_DELAY:  sel_q  <= cfg_wdata;
        ADDR_MASK:   mask_q <= cfg_wdata;
        default:     ;
      endcase
    end
  end

  // Sticky fault: an event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flt_q <= 1'b0;
    else if (prot_evt) flt_q <= 1'b1;
    else if (clr_req)  flt_q <= 1'b0;
  end

  assign kill_lo = !en_q || (flt_q && mask_q[0]);
  assign kill_hi = !en_q || (flt_q && mask_q[1]);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && !clr_req) |=> flt_q); // R9
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    prot_evt |=> flt_q); // R8
  AST_LO_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_evt && mask_q[0] && !(cfg_we && cfg_addr == ADDR_MASK)) |=> kill_lo); // R8
  AST_HI_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_evt && mask_q[1] && !(cfg_we && cfg_addr == ADDR_MASK)) |=> kill_hi); // R8

endmodule

// File: rtl/gdc_edge_filter.sv
module gdc_edge_filter #(
  parameter int CLK_NS    = 5,
  parameter bit HIGH_SIDE = 1'b0,
  parameter int CW        = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic [1:0] sel,
  input  logic       pwm_i,
  output logic       drv_o
);
  import gdc_pkg::*;

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] fresh_lim;
  logic [CW-1:0] lim_use;

  // Delay for an edge toward the current input level, from the live setting
  always_comb begin
    fresh_lim = CW'(ns_to_cycles(edge_ns(HIGH_SIDE, pwm_i, sel), CLK_NS));
  end

  // The live setting is used only on the first timed cycle, then held
  assign lim_use = (cnt_q == '0) ? fresh_lim : lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (kill) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (pwm_i == lvl_q) begin
      cnt_q <= '0;
    end else begin
      if (cnt_q == '0) lim_q <= fresh_lim;
      if (cnt_q == lim_use - 1'b1) begin
        lvl_q <= pwm_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drv_o = lvl_q && !kill;

  AST_RISE_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(pwm_i)); // R6
  AST_FALL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> ($past(!pwm_i) || $past(kill))); // R6
  AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < lim_q)); // R7

endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl #(
  parameter int CLK_NS = 5,
  parameter int NUM_LO = 3,
  parameter int NUM_HI = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [1:0]               cfg_wdata,
  input  logic                     prot_evt,
  input  logic [NUM_LO+NUM_HI-1:0] pwm_in,
  output logic [NUM_LO-1:0]        drv_lo,
  output logic [NUM_HI-1:0]        drv_hi
);
  import gdc_pkg::*;

  localparam int MAX_CYC = max_cycles(CLK_NS);
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [1:0] sel_q;
  logic       kill_lo;
  logic       kill_hi;

  gdc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .prot_evt  (prot_evt),
    .sel_q     (sel_q),
    .kill_lo   (kill_lo),
    .kill_hi   (kill_hi)
  );

  for (genvar i = 0; i < NUM_LO; i++) begin : g_lo
    gdc_edge_filter #(.CLK_NS(CLK_NS), .HIGH_SIDE(1'b0), .CW(CW)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (kill_lo),
      .sel   (sel_q),
      .pwm_i (pwm_in[i]),
      .drv_o (drv_lo[i])
    );
  end

  for (genvar j = 0; j < NUM_HI; j++) begin : g_hi
    gdc_edge_filter #(.CLK_NS(CLK_NS), .HIGH_SIDE(1'b1), .CW(CW)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (kill_hi),
      .sel   (sel_q),
      .pwm_i (pwm_in[NUM_LO+j]),
      .drv_o (drv_hi[j])
    );
  end

  AST_DISABLE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_ENABLE && !cfg_wdata[0]) |=> (drv_lo == '0 && drv_hi == '0)); // R10
  AST_NO_INSTANT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo[0]) |-> $past(pwm_in[0])); // R6

endmodule

// File: tb/tb_gate_drive_ctrl.sv
`timescale 1ns/1ps
module tb_gate_drive_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [1:0] cfg_wdata = 2'd0;
  logic       prot_evt = 1'b0;
  logic [5:0] pwm_in = 6'd0;
  logic [2:0] drv_lo;
  logic [2:0] drv_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gate_drive_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .prot_evt(prot_evt), .pwm_in(pwm_in),
    .drv_lo(drv_lo), .drv_hi(drv_hi)
  );

  // Bench-side delay table in cycles at 5 ns per cycle
  function automatic int exp_cyc(input bit hs, input bit rise, input int sel);
    int ns;
    if (!hs && rise)      ns = (sel == 0) ? 130 : (sel == 1) ? 170 : (sel == 2) ? 230 : 360;
    else if (!hs)         ns = (sel == 0) ? 140 : (sel == 1) ? 180 : (sel == 2) ? 250 : 380;
    else if (rise)        ns = (sel == 0) ? 160 : (sel == 1) ? 200 : (sel == 2) ? 260 : 380;
    else                  ns = (sel == 0) ? 140 : (sel == 1) ? 180 : (sel == 2) ? 240 : 370;
    return (ns + 4) / 5;
  endfunction

  function automatic logic outbit(input int ch);
    return (ch < 3) ? drv_lo[ch] : drv_hi[ch-3];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; prot_evt = 1'b0; pwm_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Count negedges until the output of ch changes; expected count given
  task automatic wait_change(input int ch, input int expn, input string tag);
    logic start;
    int n;
    start = outbit(ch);
    n = 0;
    while (outbit(ch) == start && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == expn, tag, n, expn);
  endtask

  task automatic measure(input int ch, input logic val, input int expn, input string tag);
    @(negedge clk);
    pwm_in[ch] = val;
    wait_change(ch, expn, tag);
  endtask

  // Reference model state for the random phase
  bit       m_lvl [6];
  int       m_cnt [6];
  int       m_lim [6];
  bit       m_en;
  int       m_sel;
  bit [1:0] m_mask;
  bit       m_flt;

  task automatic model_reset();
    for (int c = 0; c < 6; c++) begin m_lvl[c] = 0; m_cnt[c] = 0; m_lim[c] = 0; end
    m_en = 0; m_sel = 0; m_mask = 0; m_flt = 0;
  endtask

  task automatic model_step(output logic [5:0] expo);
    bit kl, kh, k;
    int lim;
    kl = !m_en || (m_flt && m_mask[0]);
    kh = !m_en || (m_flt && m_mask[1]);
    for (int c = 0; c < 6; c++) begin
      k = (c < 3) ? kl : kh;
      if (k) begin m_lvl[c] = 0; m_cnt[c] = 0; end
      else if (pwm_in[c] == m_lvl[c]) m_cnt[c] = 0;
      else begin
        lim = (m_cnt[c] == 0) ? exp_cyc(c >= 3, pwm_in[c], m_sel) : m_lim[c];
        if (m_cnt[c] == 0) m_lim[c] = lim;
        if (m_cnt[c] == lim - 1) begin m_lvl[c] = pwm_in[c]; m_cnt[c] = 0; end
        else m_cnt[c]++;
      end
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: m_en = cfg_wdata[0];
        2'd1: m_sel = cfg_wdata;
        2'd2: m_mask = cfg_wdata;
        default: ;
      endcase
    end
    if (prot_evt) m_flt = 1;
    else if (cfg_we && cfg_addr == 2'd3 && cfg_wdata[0]) m_flt = 0;
    kl = !m_en || (m_flt && m_mask[0]);
    kh = !m_en || (m_flt && m_mask[1]);
    for (int c = 0; c < 6; c++) expo[c] = m_lvl[c] && !((c < 3) ? kl : kh);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] expo;
    int n;
    void'($urandom(32'd4242));
    do_reset();
    @(negedge clk);
    check({drv_hi, drv_lo} == 6'd0, "R1 reset outputs", {drv_hi, drv_lo}, 0);

    // R2: disabled holds all low
    pwm_in = 6'h3F;
    repeat (100) @(negedge clk);
    check({drv_hi, drv_lo} == 6'd0, "R2 disabled outputs", {drv_hi, drv_lo}, 0);
    pwm_in = '0;
    wr(2'd0, 2'd1);
    measure(0, 1'b1, exp_cyc(0, 1, 0), "R2 rise after enable");
    measure(0, 1'b0, exp_cyc(0, 0, 0), "R4 lo fall sel0");

    // R4 / R5: all settings, both sides
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, s[1:0]);
      measure(0, 1'b1, exp_cyc(0, 1, s), "R4 lo rise");
      measure(0, 1'b0, exp_cyc(0, 0, s), "R4 lo fall");
      measure(5, 1'b1, exp_cyc(1, 1, s), "R5 hi rise");
      measure(5, 1'b0, exp_cyc(1, 0, s), "R5 hi fall");
    end
    wr(2'd1, 2'd0);

    // R3: mapping
    pwm_in = 6'b101010;
    repeat (100) @(negedge clk);
    check(drv_lo == 3'b010 && drv_hi == 3'b101, "R3 map A", {drv_hi, drv_lo}, 6'b101010);
    pwm_in = 6'b010101;
    repeat (100) @(negedge clk);
    check(drv_lo == 3'b101 && drv_hi == 3'b010, "R3 map B", {drv_hi, drv_lo}, 6'b010101);

    // R6: pulses one cycle short
    pwm_in = 6'b001000;
    repeat (100) @(negedge clk);
    pwm_in[1] = 1'b1;
    repeat (exp_cyc(0, 1, 0) - 1) @(negedge clk);
    pwm_in[1] = 1'b0;
    n = 0;
    repeat (60) begin @(negedge clk); if (drv_lo[1]) n++; end
    check(n == 0, "R6 lo short pulse", n, 0);
    pwm_in[3] = 1'b0;
    repeat (exp_cyc(1, 0, 0) - 1) @(negedge clk);
    pwm_in[3] = 1'b1;
    n = 0;
    repeat (60) begin @(negedge clk); if (!drv_hi[0]) n++; end
    check(n == 0, "R6 hi short gap", n, 0);

    // R7: setting change during a timed edge
    pwm_in = '0;
    repeat (100) @(negedge clk);
    pwm_in[2] = 1'b1;
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 2'd3;
    @(negedge clk); n++;
    cfg_we = 1'b0;
    while (!drv_lo[2] && n < 200) begin @(negedge clk); n++; end
    check(n == exp_cyc(0, 1, 0), "R7 edge keeps old delay", n, exp_cyc(0, 1, 0));
    measure(2, 1'b0, exp_cyc(0, 0, 3), "R7 next edge new delay");
    wr(2'd1, 2'd0);

    // R8 / R11 / R9: faults
    pwm_in = 6'h3F;
    repeat (100) @(negedge clk);
    wr(2'd2, 2'b01);
    prot_evt = 1'b1;
    @(negedge clk);
    prot_evt = 1'b0;
    check(drv_lo == 3'b000, "R8 lo forced off", drv_lo, 0);
    check(drv_hi == 3'b111, "R11 hi unaffected", drv_hi, 7);
    repeat (40) @(negedge clk);
    check(drv_lo == 3'b000, "R9 fault held", drv_lo, 0);
    prot_evt = 1'b1;
    wr(2'd3, 2'd1);
    prot_evt = 1'b0;
    repeat (40) @(negedge clk);
    check(drv_lo == 3'b000, "R9 clear during event ignored", drv_lo, 0);
    wr(2'd3, 2'd1);
    wait_change(0, exp_cyc(0, 1, 0), "R9 recover after clear");
    check(drv_lo == 3'b111, "R9 all lo back", drv_lo, 7);
    wr(2'd2, 2'b10);
    prot_evt = 1'b1;
    @(negedge clk);
    prot_evt = 1'b0;
    check(drv_hi == 3'b000 && drv_lo == 3'b111, "R8 hi only", {drv_hi, drv_lo}, 6'b000111);
    wr(2'd3, 2'd1);
    repeat (100) @(negedge clk);
    check(drv_hi == 3'b111, "R9 hi back", drv_hi, 7);

    // R10: disable is immediate
    wr(2'd0, 2'd0);
    check({drv_hi, drv_lo} == 6'd0, "R10 disable fast", {drv_hi, drv_lo}, 0);

    // Random phase against the model
    do_reset();
    model_reset();
    pwm_in = '0;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      @(negedge clk);
      model_step(expo);
      check({drv_hi, drv_lo} == expo, "R6 random model", {drv_hi, drv_lo}, expo);
      for (int c = 0; c < 6; c++) if ($urandom_range(39) == 0) pwm_in[c] = ~pwm_in[c];
      prot_evt = ($urandom_range(399) == 0);
      if (cyc == 0) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 2'd1;
      end else if ($urandom_range(49) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 2'($urandom_range(3));
        cfg_wdata = 2'($urandom_range(3));
        if (cfg_addr == 2'd0) cfg_wdata[0] = ($urandom_range(4) != 0);
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule